// File: doc/BRIEF.md
# Protected Watchdog Timer with Interrupt Response

This block is a watchdog counter that software must refresh before a selectable timeout runs out. Time advances on a one-cycle tick input, whose period is set by the parameter `BASE_TICKS`: the number of ticks in the shortest timeout, nominally 15.625 ms. When the count runs out, the block either pulses a system reset output for `RST_LEN` clock cycles or, when interrupt response is selected, raises an interrupt instead. In both cases it sets a sticky status flag.

The single 8-bit control register is guarded by a two-step unlock. A write with bit 0 set arms the register for exactly the next cycle. Only a write made in that cycle is accepted. Every accepted write restarts the count, and this is how the watchdog is refreshed. Timeout code 1000 requests an immediate reset. Codes 1001 to 1111 are reserved and do not change the stored timeout.

Control register layout, as written on `wr_data_i` and read on `ctrl_o`:

| Bits | Field |
|------|-------|
| [7:4] | timeout code |
| [3] | interrupt response |
| [2] | status |
| [1] | enable |
| [0] | unlock on write, armed on read |

Top module: `watchdog_guard`

## Requirements
- R1: After reset, `ctrl_o` reads 8'h70, and `wdt_rst_o` and `wdt_irq_o` are low. In that value the code is 0111, and interrupt response, status, enable and armed are all 0.
- R2: While enabled, codes 0000 to 0111 select a timeout of `BASE_TICKS << code` ticks, counted from the last accepted write. The timeout output rises on the cycle after the final tick.
- R3: When a timeout occurs with interrupt response 0, `wdt_rst_o` goes high for exactly `RST_LEN` cycles and the count restarts.
- R4: When a timeout occurs with interrupt response 1, `wdt_irq_o` goes high and `wdt_rst_o` stays low. `wdt_irq_o` equals status AND interrupt response.
- R5: Every timeout and every forced reset sets status (bit 2). The status bit stays set until an accepted write with bit 2 = 0 clears it. Writing 1 to bit 2 leaves it unchanged.
- R6: While enable (bit 1) is 0, ticks are not counted and no timeout occurs.
- R7: A write is accepted only in the cycle right after a write with bit 0 = 1. Any other write leaves bits [7:1] unchanged. Armed (bit 0 of `ctrl_o`) reads 1 only during the accepting cycle.
- R8: An accepted write restarts the count from zero, and this is the refresh mechanism.
- R9: An accepted write with code 1000 raises `wdt_rst_o` on the next cycle, whatever the state of enable. It leaves the stored code unchanged.
- R10: An accepted write with a reserved code (1001 to 1111) leaves the stored code unchanged. The other fields are still written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle time base tick |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| ctrl_o | output | 8 | Control register readback |
| wdt_rst_o | output | 1 | Reset request pulse |
| wdt_irq_o | output | 1 | Watchdog interrupt |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle:
- writes are ignored unless the register is armed;
- an accepted write clears the count;
- a reserved code is dropped;
- code 1000 gives a reset on the next cycle;
- a disabled counter holds its value;
- a rising reset always comes with status set;
- each expiry is routed to either the interrupt or the reset.

Only the bench's scenarios can show the following:
- the exact timeout length for several codes;
- the width of the reset pulse;
- that regular refreshes keep the reset away;
- that a status flag stays set until a write clears it.

// File: rtl/watchdog_guard.sv
module watchdog_guard #(
  parameter int BASE_TICKS = 125,
  parameter int RST_LEN    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] ctrl_o,
  output logic       wdt_rst_o,
  output logic       wdt_irq_o
);
  localparam int CW = $clog2(BASE_TICKS * 128 + 1);
  localparam int RW = $clog2(RST_LEN + 1);
  localparam logic [3:0] FORCE_CODE = 4'b1000;

  logic [2:0]    code_q;
  logic          irq_q, stat_q, en_q, armed_q;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] rcnt_q;

  logic [CW-1:0] limit;
  logic          accept, force_rst, fire, code_ok;

  assign limit     = CW'(BASE_TICKS) << code_q;
  assign accept    = wr_en_i && armed_q;
  assign code_ok   = !wr_data_i[7];
  assign force_rst = accept && (wr_data_i[7:4] == FORCE_CODE);
  assign fire      = !accept && en_q && tick_i && (cnt_q == limit - 1'b1);

  assign ctrl_o    = {1'b0, code_q, irq_q, stat_q, en_q, armed_q};
  assign wdt_rst_o = (rcnt_q != '0);
  assign wdt_irq_o = stat_q && irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      code_q  <= 3'd7;
      irq_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      armed_q <= wr_en_i && wr_data_i[0] && !armed_q;
      if (accept) begin
        if (code_ok) code_q <= wr_data_i[6:4];
        irq_q <= wr_data_i[3];
        en_q  <= wr_data_i[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (accept || fire) begin
      cnt_q <= '0;
    end else if (en_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
    end else if (fire || force_rst) begin
      stat_q <= 1'b1;
    end else if (accept && !wr_data_i[2]) begin
      stat_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q <= '0;
    end else if (force_rst || (fire && !irq_q)) begin
      rcnt_q <= RW'(RST_LEN);
    end else if (rcnt_q != '0) begin
      rcnt_q <= rcnt_q - 1'b1;
    end
  end

  p_locked_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !armed_q) |=> (ctrl_o[7:1] == $past(ctrl_o[7:1]) || $rose(ctrl_o[2])));

  p_refresh_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cnt_q == '0));

  p_reserved_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_data_i[7:4] > FORCE_CODE) |=> (ctrl_o[6:4] == $past(ctrl_o[6:4])));

  p_force_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_data_i[7:4] == FORCE_CODE) |=> (wdt_rst_o && ctrl_o[2]));

  p_disabled_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !accept) |=> $stable(cnt_q));

  p_rst_with_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> ctrl_o[2]);

  p_irq_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && irq_q) |=> (wdt_irq_o && !$rose(wdt_rst_o)));

  p_rst_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !irq_q) |=> wdt_rst_o);
endmodule

// File: tb/watchdog_guard_test.sv
module watchdog_guard_test;
  localparam int BT = 4;
  localparam int RL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b1;
  logic wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] ctrl_o;
  logic wdt_rst_o, wdt_irq_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  watchdog_guard #(.BASE_TICKS(BT), .RST_LEN(RL)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .ctrl_o(ctrl_o), .wdt_rst_o(wdt_rst_o),
    .wdt_irq_o(wdt_irq_o));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 8'h01;
    @(negedge clk); wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0; wr_data_i = 8'h00;
  endtask

  task automatic wait_out(input bit use_irq, output int n);
    n = 0;
    while (n < 3000) begin
      @(negedge clk); n++;
      if (use_irq ? wdt_irq_o : wdt_rst_o) break;
    end
  endtask

  task automatic quiesce();
    do_write(8'h00);
    repeat (RL + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 ctrl", ctrl_o, 8'h70);
    check("R1 rst", wdt_rst_o, 0);
    check("R1 irq", wdt_irq_o, 0);
  endtask

  task automatic t_timeout_reset();
    int n;
    do_write(8'h02);
    wait_out(0, n);
    check("R2 code0 period", n, BT);
    check("R5 status set", ctrl_o[2], 1);
    check("R4 no irq when reset", wdt_irq_o, 0);
    @(negedge clk); check("R3 pulse 2", wdt_rst_o, 1);
    @(negedge clk); check("R3 pulse 3", wdt_rst_o, 1);
    @(negedge clk); check("R3 pulse end", wdt_rst_o, 0);
    check("R5 status sticky", ctrl_o[2], 1);
    quiesce();
    check("R5 status cleared", ctrl_o[2], 0);
  endtask

  task automatic t_periods();
    int n;
    for (int c = 2; c <= 4; c++) begin
      do_write(8'((c << 4) | 2));
      wait_out(0, n);
      check($sformatf("R2 code%0d period", c), n, BT << c);
      quiesce();
    end
  endtask

  task automatic t_irq();
    int n;
    bit saw_rst = 0;
    do_write(8'h0A);
    n = 0;
    while (n < 100 && !wdt_irq_o) begin
      @(negedge clk); n++;
      if (wdt_rst_o) saw_rst = 1;
    end
    check("R4 irq period", n, BT);
    repeat (10) begin
      @(negedge clk);
      if (wdt_rst_o) saw_rst = 1;
    end
    check("R4 no reset", saw_rst, 0);
    check("R4 irq held", wdt_irq_o, 1);
    do_write(8'h08);
    check("R5 clear irq", wdt_irq_o, 0);
    quiesce();
  endtask

  task automatic t_refresh();
    bit saw = 0;
    do_write(8'h12);
    repeat (6) begin
      repeat (5) begin
        @(negedge clk);
        if (wdt_rst_o) saw = 1;
      end
      do_write(8'h12);
    end
    check("R8 refresh holds off reset", saw, 0);
    quiesce();
  endtask

  task automatic t_disable();
    bit saw = 0;
    do_write(8'h00);
    repeat (200) begin
      @(negedge clk);
      if (wdt_rst_o || wdt_irq_o) saw = 1;
    end
    check("R6 disabled no timeout", saw, 0);
  endtask

  task automatic t_protect();
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 8'h32;
    @(negedge clk); wr_en_i = 1'b0;
    check("R7 unarmed write ignored", ctrl_o, 8'h00);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 8'h01;
    @(negedge clk); wr_en_i = 1'b0; wr_data_i = 8'h00;
    check("R7 armed visible", ctrl_o[0], 1);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 8'h32;
    @(negedge clk); wr_en_i = 1'b0;
    check("R7 late write ignored", ctrl_o, 8'h00);
  endtask

  task automatic t_force();
    do_write(8'h60);
    do_write(8'h80);
    check("R9 immediate reset", wdt_rst_o, 1);
    check("R9 code kept", ctrl_o[6:4], 6);
    check("R5 status on force", ctrl_o[2], 1);
    repeat (RL + 2) @(negedge clk);
    check("R9 no repeat", wdt_rst_o, 0);
  endtask

  task automatic t_reserved();
    do_write(8'hB8);
    check("R10 code kept", ctrl_o[6:4], 6);
    check("R10 other fields written", ctrl_o[3], 1);
    check("R10 status cleared", ctrl_o[2], 0);
    check("R10 no reset", wdt_rst_o, 0);
    do_write(8'h00);
  endtask

  initial begin : watchdog
    repeat (150000) @(negedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_timeout_reset();
    t_periods();
    t_irq();
    t_refresh();
    t_disable();
    t_protect();
    t_force();
    t_reserved();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule